// File: doc/BRIEF.md
# Float to Integer Converter

This block turns one IEEE-754 binary32 or binary64 operand into a signed two's-complement integer of 32 or 64 bits. Each request selects the rounding rule for that request alone: nearest with ties to even, chop toward zero, toward plus infinity or toward minus infinity. The rule is taken from the request's operation code and never from any shared rounding setting, so a conversion leaves no state behind that a later floating-point operation could see.

A request is a one-cycle strobe with the operand, a source format select, a destination width select and the operation code. One clock later the block presents the integer, three cause flags (invalid, overflow, inexact) and a one-cycle done pulse. The flags are worked out first, and the integer is then replaced by the largest positive value of the destination width whenever invalid or overflow is set, whatever the sign of the operand.

Top module: `f2iConv`

## Requirements
- R1: With roundOp = 2'b00 the result is the nearest integer, and an exact half goes to the even neighbour (2.5 gives 2, -2.5 gives -2, 3.5 gives 4).
- R2: With roundOp = 2'b01 the fraction is dropped toward zero (-1.7 gives -1, 1.7 gives 1).
- R3: With roundOp = 2'b10 the result is the smallest integer not below the operand; with roundOp = 2'b11 it is the largest integer not above it.
- R4: fmtDouble = 1 reads operandIn as binary64; fmtDouble = 0 reads operandIn[31:0] as binary32 and ignores operandIn[63:32]; dstLong = 1 selects a 64-bit destination, dstLong = 0 a 32-bit one; every pairing works with every roundOp.
- R5: A NaN or infinite operand raises invalidFlag and yields 0x7FFFFFFF (word) or 0x7FFFFFFFFFFFFFFF (long), also for negative operands.
- R6: A finite operand whose rounded value falls outside the destination range (word: -2^31 to 2^31-1, long: -2^63 to 2^63-1) raises overflowFlag and yields the same maximum positive value as R5, also for negative operands.
- R7: inexactFlag is raised exactly when nonzero fraction bits are discarded and neither invalidFlag nor overflowFlag is raised.
- R8: A subnormal operand converts to 0, +1 or -1 as the rounding rule gives and raises inexactFlag.
- R9: Positive or negative zero converts to 0 with no flag raised.
- R10: resultOut, the flags and doneOut appear on the clock edge after the edge that sees validIn high; doneOut is high for that one cycle per request, and the outputs hold their values while validIn is low; reset clears all of them.
- R11: A word result appears in resultOut[31:0] sign-extended into resultOut[63:32], and invalidFlag and overflowFlag are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| validIn | input | 1 | Request strobe, one cycle per conversion |
| operandIn | input | 64 | Floating-point operand; binary32 in bits 31:0 |
| fmtDouble | input | 1 | 1 = binary64 source, 0 = binary32 source |
| dstLong | input | 1 | 1 = 64-bit destination, 0 = 32-bit destination |
| roundOp | input | 2 | 00 nearest-even, 01 toward zero, 10 up, 11 down |
| resultOut | output | 64 | Converted integer, word results sign-extended |
| invalidFlag | output | 1 | Operand was NaN or infinite |
| overflowFlag | output | 1 | Rounded value outside destination range |
| inexactFlag | output | 1 | Fraction discarded without invalid or overflow |
| doneOut | output | 1 | One-cycle pulse marking new outputs |

## Verification
Rounding and range checking meet in the same cycle when an operand sits just inside the destination limit and the rounding rule carries it across: 2147483647.5 rounded up or to nearest into a word, or -2147483648.5 rounded down, must turn a would-be inexact result into an overflow with the saturated value and no inexact flag. The bench drives these edges in all four rules and both widths and compares flags and integer against a reference built from real-number floor and ceiling arithmetic. Random operands with exponents spread around the word and long limits keep hitting that boundary from both sides.

// File: rtl/f2iPkg.sv
package f2iPkg;
  localparam int DATA_W   = 64;
  localparam int WORD_W   = 32;
  localparam int D_EXP_W  = 11;
  localparam int D_MAN_W  = 52;
  localparam int S_EXP_W  = 8;
  localparam int S_MAN_W  = 23;
  localparam int D_BIAS   = (1 << (D_EXP_W - 1)) - 1;
  localparam int S_BIAS   = (1 << (S_EXP_W - 1)) - 1;
  localparam int SIG_W    = D_MAN_W + 1;
  localparam int EXP_IW   = D_EXP_W + 2;
  localparam int SH_W     = 6;

  typedef enum logic [1:0] {
    RND_NEAR  = 2'b00,
    RND_ZERO  = 2'b01,
    RND_UP    = 2'b10,
    RND_DOWN  = 2'b11
  } roundOp_e;

  typedef struct packed {
    logic capture;
    logic done;
  } ctrlStrobe_t;
endpackage

// File: rtl/f2iCtrl.sv
module f2iCtrl
  import f2iPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  output ctrlStrobe_t strobe
);
  logic doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) doneQ <= 1'b0;
    else       doneQ <= validIn;
  end

  always_comb begin
    strobe.capture = validIn & rstN;
    strobe.done    = doneQ;
  end
endmodule

// File: rtl/f2iDatapath.sv
module f2iDatapath
  import f2iPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] operandIn,
  input  logic              fmtDouble,
  input  logic              dstLong,
  input  logic [1:0]        roundOp,
  output logic [DATA_W-1:0] resultQ,
  output logic              invalidQ,
  output logic              overflowQ,
  output logic              inexactQ
);
  logic               sgn;
  logic [D_EXP_W-1:0] expField;
  logic [D_MAN_W-1:0] manField;
  logic               expAllOnes;
  logic               expZero;
  logic [SIG_W-1:0]   sig;
  logic signed [EXP_IW-1:0] eUnb;
  logic [SH_W-1:0]    shAmt;
  logic [DATA_W-1:0]  mag;
  logic [DATA_W-1:0]  fracBits;
  logic [DATA_W-1:0]  halfBit;
  logic               guardBit;
  logic               stickyBit;
  logic               bigExp;
  logic               roundInc;
  logic [DATA_W:0]    magRnd;
  logic [DATA_W:0]    posLimit;
  logic [DATA_W:0]    limit;
  logic               outOfRange;
  logic               invalidC;
  logic               overflowC;
  logic               inexactC;
  logic [DATA_W:0]    signedVal;
  logic [DATA_W-1:0]  resultC;

  // Unpack into a common binary64-shaped significand and unbiased exponent
  always_comb begin
    if (fmtDouble) begin
      sgn        = operandIn[DATA_W-1];
      expField   = operandIn[DATA_W-2 -: D_EXP_W];
      manField   = operandIn[D_MAN_W-1:0];
      expAllOnes = &operandIn[DATA_W-2 -: D_EXP_W];
      expZero    = ~|operandIn[DATA_W-2 -: D_EXP_W];
      eUnb       = expZero ? EXP_IW'(1 - D_BIAS)
                           : $signed({2'b00, expField}) - EXP_IW'(D_BIAS);
    end else begin
      sgn        = operandIn[WORD_W-1];
      expField   = {{(D_EXP_W-S_EXP_W){1'b0}}, operandIn[WORD_W-2 -: S_EXP_W]};
      manField   = {operandIn[S_MAN_W-1:0], {(D_MAN_W-S_MAN_W){1'b0}}};
      expAllOnes = &operandIn[WORD_W-2 -: S_EXP_W];
      expZero    = ~|operandIn[WORD_W-2 -: S_EXP_W];
      eUnb       = expZero ? EXP_IW'(1 - S_BIAS)
                           : $signed({2'b00, expField}) - EXP_IW'(S_BIAS);
    end
    sig = {~expZero, manField};
  end

  // Integer magnitude plus guard and sticky bits
  always_comb begin
    mag       = '0;
    fracBits  = '0;
    halfBit   = '0;
    guardBit  = 1'b0;
    stickyBit = 1'b0;
    bigExp    = 1'b0;
    shAmt     = '0;
    if (expAllOnes || sig == '0) begin
      mag = '0;
    end else if (eUnb < 0) begin
      if (eUnb == -1) begin
        guardBit  = sig[SIG_W-1];
        stickyBit = |sig[SIG_W-2:0];
      end else begin
        stickyBit = 1'b1;
      end
    end else if (eUnb <= EXP_IW'(D_MAN_W)) begin
      shAmt     = SH_W'(EXP_IW'(D_MAN_W) - eUnb);
      mag       = {{(DATA_W-SIG_W){1'b0}}, sig} >> shAmt;
      fracBits  = {{(DATA_W-SIG_W){1'b0}}, sig} & ((64'd1 << shAmt) - 64'd1);
      halfBit   = (shAmt == '0) ? '0 : (64'd1 << (shAmt - SH_W'(1)));
      guardBit  = |(fracBits & halfBit);
      stickyBit = |(fracBits & (halfBit - 64'd1));
    end else if (eUnb <= EXP_IW'(DATA_W - 1)) begin
      shAmt = SH_W'(eUnb - EXP_IW'(D_MAN_W));
      mag   = {{(DATA_W-SIG_W){1'b0}}, sig} << shAmt;
    end else begin
      bigExp = 1'b1;
    end
  end

  // Per-operation rounding direction, independent of any shared mode
  always_comb begin
    unique case (roundOp_e'(roundOp))
      RND_NEAR: roundInc = guardBit & (stickyBit | mag[0]);
      RND_ZERO: roundInc = 1'b0;
      RND_UP:   roundInc = ~sgn & (guardBit | stickyBit);
      RND_DOWN: roundInc = sgn & (guardBit | stickyBit);
      default:  roundInc = 1'b0;
    endcase
    magRnd = {1'b0, mag} + {{DATA_W{1'b0}}, roundInc};
  end

  // Flags first, then saturation decided from them
  always_comb begin
    posLimit   = dstLong ? {2'b00, {(DATA_W-1){1'b1}}}
                         : {{(DATA_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
    limit      = sgn ? posLimit + 65'd1 : posLimit;
    outOfRange = bigExp | (magRnd > limit);
    invalidC   = expAllOnes;
    overflowC  = ~invalidC & outOfRange;
    inexactC   = ~invalidC & ~overflowC & (guardBit | stickyBit);
    signedVal  = sgn ? (~magRnd + 65'd1) : magRnd;
    if (invalidC || overflowC)
      resultC = dstLong ? {1'b0, {(DATA_W-1){1'b1}}}
                        : {{(DATA_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
    else if (dstLong)
      resultC = signedVal[DATA_W-1:0];
    else
      resultC = {{(DATA_W-WORD_W){signedVal[WORD_W-1]}}, signedVal[WORD_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ   <= '0;
      invalidQ  <= 1'b0;
      overflowQ <= 1'b0;
      inexactQ  <= 1'b0;
    end else if (strobe.capture) begin
      resultQ   <= resultC;
      invalidQ  <= invalidC;
      overflowQ <= overflowC;
      inexactQ  <= inexactC;
    end
  end
endmodule

// File: rtl/f2iConv.sv
module f2iConv
  import f2iPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic [63:0] operandIn,
  input  logic        fmtDouble,
  input  logic        dstLong,
  input  logic [1:0]  roundOp,
  output logic [63:0] resultOut,
  output logic        invalidFlag,
  output logic        overflowFlag,
  output logic        inexactFlag,
  output logic        doneOut
);
  ctrlStrobe_t strobe;

  f2iCtrl ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .strobe  (strobe)
  );

  f2iDatapath dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .operandIn (operandIn),
    .fmtDouble (fmtDouble),
    .dstLong   (dstLong),
    .roundOp   (roundOp),
    .resultQ   (resultOut),
    .invalidQ  (invalidFlag),
    .overflowQ (overflowFlag),
    .inexactQ  (inexactFlag)
  );

  assign doneOut = strobe.done;
endmodule

// File: rtl/f2iConvChk.sv
module f2iConvChk (
  input logic        clk,
  input logic        rstN,
  input logic        validIn,
  input logic [63:0] operandIn,
  input logic        fmtDouble,
  input logic        dstLong,
  input logic [1:0]  roundOp,
  input logic [63:0] resultOut,
  input logic        invalidFlag,
  input logic        overflowFlag,
  input logic        inexactFlag,
  input logic        doneOut
);
  // R10
  done_follows_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> doneOut);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !doneOut);

  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> ($stable(resultOut) && $stable(invalidFlag) && $stable(overflowFlag)));

  // R5
  sat_long_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && dstLong) |=> ((invalidFlag || overflowFlag) -> resultOut == 64'h7FFF_FFFF_FFFF_FFFF));

  // R6
  sat_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !dstLong) |=> ((invalidFlag || overflowFlag) -> resultOut == 64'h0000_0000_7FFF_FFFF));

  // R7
  inexact_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    inexactFlag |-> (!invalidFlag && !overflowFlag));

  // R11
  no_dual_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(invalidFlag && overflowFlag));

  // R11
  word_sext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !dstLong) |=> (resultOut[63:32] == {32{resultOut[31]}}));
endmodule

bind f2iConv f2iConvChk chk (.*);

// File: tb/f2iConv_test.sv
`timescale 1ns/1ps
module f2iConv_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [63:0] operandIn = '0;
  logic        fmtDouble = 1'b0;
  logic        dstLong = 1'b0;
  logic [1:0]  roundOp = 2'b00;
  logic [63:0] resultOut;
  logic        invalidFlag, overflowFlag, inexactFlag, doneOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  f2iConv uut (
    .clk(clk), .rstN(rstN), .validIn(validIn), .operandIn(operandIn),
    .fmtDouble(fmtDouble), .dstLong(dstLong), .roundOp(roundOp),
    .resultOut(resultOut), .invalidFlag(invalidFlag), .overflowFlag(overflowFlag),
    .inexactFlag(inexactFlag), .doneOut(doneOut)
  );

  function automatic real pow2(input int e);
    real r = 1.0;
    if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
    else        for (int i = 0; i < -e; i++) r = r * 0.5;
    return r;
  endfunction

  function automatic bit isSpecial(input bit dbl, input logic [63:0] b);
    return dbl ? (b[62:52] == 11'h7FF) : (b[30:23] == 8'hFF);
  endfunction

  function automatic real toReal(input bit dbl, input logic [63:0] b);
    real m;
    int  e;
    if (dbl) return $bitstoreal(b);
    if (b[30:23] == 8'h00) begin
      m = real'(b[22:0]);
      e = -149;
    end else begin
      m = real'({1'b1, b[22:0]});
      e = int'(b[30:23]) - 150;
    end
    m = m * pow2(e);
    return b[31] ? -m : m;
  endfunction

  function automatic real roundRef(input real v, input logic [1:0] op);
    real f, d;
    case (op)
      2'b00: begin
        f = $floor(v);
        d = v - f;
        if (d > 0.5) return f + 1.0;
        if (d < 0.5) return f;
        return ($floor(f / 2.0) * 2.0 == f) ? f : f + 1.0;
      end
      2'b01: return (v >= 0.0) ? $floor(v) : $ceil(v);
      2'b10: return $ceil(v);
      default: return $floor(v);
    endcase
  endfunction

  task automatic expectOf(input bit dbl, input bit lng, input logic [1:0] op,
                          input logic [63:0] b, output logic [63:0] er,
                          output logic [2:0] ef);
    real v, r;
    longint t;
    if (isSpecial(dbl, b)) begin
      er = lng ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h7FFF_FFFF;
      ef = 3'b100;
      return;
    end
    v = toReal(dbl, b);
    r = roundRef(v, op);
    if (lng ? (r >= 9.223372036854775808e18 || r < -9.223372036854775808e18)
            : (r > 2147483647.0 || r < -2147483648.0)) begin
      er = lng ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h7FFF_FFFF;
      ef = 3'b010;
      return;
    end
    t = longint'(r);
    er = lng ? t : {{32{t[31]}}, t[31:0]};
    ef = {2'b00, (r != v)};
  endtask

  task automatic convert(input string tag, input bit dbl, input bit lng,
                         input logic [1:0] op, input logic [63:0] b);
    logic [63:0] er;
    logic [2:0]  ef;
    logic [2:0]  af;
    expectOf(dbl, lng, op, b, er, ef);
    @(negedge clk);
    operandIn = b; fmtDouble = dbl; dstLong = lng; roundOp = op; validIn = 1'b1;
    @(negedge clk);
    validIn = 1'b0;
    operandIn = $urandom;
    af = {invalidFlag, overflowFlag, inexactFlag};
    checks++;
    if (resultOut !== er || af !== ef || doneOut !== 1'b1) begin
      errors++;
      $display("FAIL %s op=%h dbl=%0d lng=%0d rnd=%0d: got res=%h flags=%b done=%b, expected res=%h flags=%b done=1",
               tag, b, dbl, lng, op, resultOut, af, doneOut, er, ef);
    end
  endtask

  function automatic logic [63:0] randD(input int lo, input int span);
    logic [63:0] b;
    b[63]    = $urandom_range(0, 1);
    b[62:52] = 11'(1023 + lo + int'($urandom_range(0, span)));
    b[51:0]  = {$urandom, $urandom} >> ($urandom_range(0, 1) * 40);
    return b;
  endfunction

  function automatic logic [63:0] randS(input int lo, input int span);
    logic [63:0] b;
    b[63:32] = $urandom;
    b[31]    = $urandom_range(0, 1);
    b[30:23] = 8'(127 + lo + int'($urandom_range(0, span)));
    b[22:0]  = 23'($urandom) >> ($urandom_range(0, 1) * 16);
    return b;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    checks++;
    if (resultOut !== '0 || invalidFlag || overflowFlag || inexactFlag || doneOut) begin
      errors++;
      $display("FAIL R10 reset state: res=%h flags=%b%b%b done=%b, expected all zero",
               resultOut, invalidFlag, overflowFlag, inexactFlag, doneOut);
    end
    rstN = 1'b1;

    // R1 ties to even
    convert("R1", 1, 0, 2'b00, $realtobits(2.5));
    convert("R1", 1, 0, 2'b00, $realtobits(-2.5));
    convert("R1", 1, 1, 2'b00, $realtobits(3.5));
    convert("R1", 1, 0, 2'b00, $realtobits(0.5));
    convert("R1", 1, 0, 2'b00, $realtobits(-0.75));
    // R2 toward zero
    convert("R2", 1, 0, 2'b01, $realtobits(-1.7));
    convert("R2", 1, 1, 2'b01, $realtobits(1.7));
    // R3 up and down
    convert("R3", 1, 0, 2'b10, $realtobits(-1.5));
    convert("R3", 1, 0, 2'b11, $realtobits(-1.5));
    convert("R3", 1, 1, 2'b10, $realtobits(7.25));
    // R4 binary32 with junk upper half
    convert("R4", 0, 0, 2'b00, {32'hDEAD_BEEF, 32'h406C_CCCD});
    convert("R4", 0, 1, 2'b11, {32'h1234_5678, 32'hC06C_CCCD});
    convert("R4", 0, 0, 2'b10, 64'h0000_0000_4F00_0000);
    // R5 NaN and infinities
    convert("R5", 1, 0, 2'b00, 64'hFFF8_0000_0000_0000);
    convert("R5", 1, 1, 2'b01, 64'hFFF0_0000_0000_0000);
    convert("R5", 0, 0, 2'b10, 64'h0000_0000_7F80_0000);
    convert("R5", 0, 1, 2'b11, 64'h0000_0000_FFC0_0001);
    // R6 range edges
    convert("R6", 1, 0, 2'b10, $realtobits(2147483647.5));
    convert("R6", 1, 0, 2'b00, $realtobits(2147483647.5));
    convert("R6", 1, 0, 2'b01, $realtobits(2147483647.5));
    convert("R6", 1, 0, 2'b11, $realtobits(-2147483648.5));
    convert("R6", 1, 0, 2'b01, $realtobits(-2147483648.5));
    convert("R6", 1, 0, 2'b00, $realtobits(-2147483648.0));
    convert("R6", 1, 0, 2'b00, $realtobits(2147483648.0));
    convert("R6", 1, 1, 2'b00, 64'hC3E0_0000_0000_0000);
    convert("R6", 1, 1, 2'b00, 64'h43E0_0000_0000_0000);
    convert("R6", 0, 1, 2'b01, 64'h0000_0000_DF00_0000);
    convert("R6", 1, 1, 2'b11, $realtobits(-1.0e30));
    // R7 exact vs inexact
    convert("R7", 1, 1, 2'b00, $realtobits(123456789.0));
    convert("R7", 1, 1, 2'b01, $realtobits(123456789.25));
    // R8 subnormals
    convert("R8", 1, 0, 2'b10, 64'h0000_0000_0000_0001);
    convert("R8", 1, 0, 2'b11, 64'h8000_0000_0000_0001);
    convert("R8", 1, 1, 2'b00, 64'h000F_FFFF_FFFF_FFFF);
    convert("R8", 0, 0, 2'b10, 64'h0000_0000_0000_0001);
    convert("R8", 0, 1, 2'b11, 64'h0000_0000_8000_0010);
    // R9 zeros
    convert("R9", 1, 0, 2'b11, 64'h8000_0000_0000_0000);
    convert("R9", 0, 1, 2'b10, 64'h0000_0000_8000_0000);
    convert("R9", 1, 1, 2'b00, 64'h0);
    // R11 negative word sign extension
    convert("R11", 1, 0, 2'b01, $realtobits(-5.9));

    // R10 done pulse and hold while idle
    @(negedge clk);
    checks++;
    if (doneOut !== 1'b0 || resultOut !== 64'hFFFF_FFFF_FFFF_FFFB) begin
      errors++;
      $display("FAIL R10 idle: done=%b res=%h, expected done=0 res=fffffffffffffffb",
               doneOut, resultOut);
    end

    // Random sweep around the limits (R1 R2 R3 R4 R6 R7)
    for (int i = 0; i < 600; i++) begin
      bit dbl = $urandom_range(0, 1);
      bit lng = $urandom_range(0, 1);
      logic [1:0] op = 2'($urandom_range(0, 3));
      logic [63:0] b = dbl ? randD(-3, 70) : randS(-3, 70);
      convert("R4 random", dbl, lng, op, b);
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule